// File: doc/BRIEF.md
# Configuration packet broadcast writer

This block is a write-only front end on a 32-bit memory-mapped bus. Software builds a 128-bit configuration packet one 32-bit word at a time in a four-word staging buffer. When the last word lands, the block hands the whole packet to every connected downstream frame controller at the same moment. Along with the packet it sends a 6-bit target register address.

There are two 4 KB windows, and a side-band select on each write picks between them. In the register window, the target register address is taken from the write address. In the frame-data window, every packet goes to one fixed frame-data register whatever the address was. Both windows share the staging buffer. Reads carry no data: they return zero and raise a one-cycle error pulse.

Top module: `cfg_bcast_writer`

## Requirements
- R1: After synchronous reset, all staging words are zero, no target strobe is high and the read error output is low. A packet completed by writing only the last word therefore carries zeros in words 0 to 2.
- R2: Address bits [3:2] choose the staging word a write fills. Writing word 3 completes the packet. One clock after that write, every connected target sees a one-cycle strobe with the data {word3, word2, word1, word0}, word 0 in bits [31:0]. Word-3 writes on consecutive cycles give strobes on consecutive cycles.
- R3: In the register window (select = 0), the packet's target register address equals bits [9:4] of the write address that completed it.
- R4: In the frame-data window (select = 1), the target register address is the parameter FDATA_ADDR (default 6'h0C), whatever the write address bits are.
- R5: A strobe reaches only the targets whose bit is set in the 15-bit parameter CONN_MASK (default 15'h7BFF, so target 10 never strobes). Every connected target strobes together.
- R6: A write whose byte enables are not all four set (4'b1111) is ignored. It changes no staging word and starts no broadcast, even if it addresses word 3.
- R7: Staging words keep their values after a broadcast until they are overwritten, and both windows write the same buffer.
- R8: A read in either window returns zero on the read data output one clock later, with the read error output high for exactly that one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request, one cycle per write |
| wr_win | input | 1 | Window select: 0 register window, 1 frame-data window |
| wr_addr | input | 12 | Byte offset within the selected 4 KB window |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte enables; only 4'b1111 is accepted |
| rd_en | input | 1 | Read request in either window |
| rd_data | output | 32 | Read data, always zero |
| rd_err | output | 1 | One-cycle error pulse for each read |
| pkt_valid | output | 15 | Per-target broadcast strobe |
| pkt_addr | output | 6 | Target register address of the packet |
| pkt_data | output | 128 | Packet data, word 0 in the low bits |

## Verification
Every result is due exactly one clock after the stimulus that causes it. The broadcast follows the edge that captures the word-3 write, and the read response follows the edge that captures the read. The driver changes inputs on the falling edge and pushes the expected packet into a queue when it presents a full word-3 write. The monitor samples on the next falling edge, so every registered output has settled by then. Any strobe that arrives with the queue empty counts as a failure, which covers the ignored partial writes. Read responses are checked one falling edge after the read is presented.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  typedef enum logic {
    WIN_REG   = 1'b0,
    WIN_FDATA = 1'b1
  } cbw_win_e;
endpackage

// File: rtl/cbw_decode.sv
module cbw_decode #(
  parameter int DATA_W     = 32,
  parameter int WORDS      = 4,
  parameter int RA_W       = 6,
  parameter int WIN_AW     = 12,
  parameter logic [RA_W-1:0] FDATA_ADDR = 6'h0C
) (
  input  logic                 wr_en,
  input  logic                 wr_win,
  input  logic [WIN_AW-1:0]    wr_addr,
  input  logic [DATA_W/8-1:0]  wr_strb,
  output logic [WORDS-1:0]     word_sel,
  output logic                 fire,
  output logic [RA_W-1:0]      tgt_addr
);
  import cbw_pkg::*;
  localparam int SEL_W  = $clog2(WORDS);
  localparam int SEL_LO = $clog2(DATA_W/8);
  localparam int RA_LO  = SEL_LO + SEL_W;

  logic             accept;
  logic [SEL_W-1:0] idx;
  logic             unused_bits;

  assign accept      = wr_en && (&wr_strb);
  assign idx         = wr_addr[SEL_LO +: SEL_W];
  assign unused_bits = ^{wr_addr[SEL_LO-1:0], wr_addr[WIN_AW-1:RA_LO+RA_W]};

  for (genvar g = 0; g < WORDS; g++) begin : g_sel
    assign word_sel[g] = accept && (idx == SEL_W'(g));
  end

  assign fire     = word_sel[WORDS-1];
  assign tgt_addr = (cbw_win_e'(wr_win) == WIN_FDATA) ? FDATA_ADDR
                                                      : wr_addr[RA_LO +: RA_W];
endmodule

// File: rtl/cbw_wbuf.sv
module cbw_wbuf #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WORDS-1:0]        word_sel,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [WORDS*DATA_W-1:0] next_img
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)              q <= '0;
      else if (word_sel[g]) q <= wr_data;
    end
    assign next_img[g*DATA_W +: DATA_W] = word_sel[g] ? wr_data : q;
  end
endmodule

// File: rtl/cbw_fanout.sv
module cbw_fanout #(
  parameter int PKT_W = 128,
  parameter int RA_W  = 6,
  parameter int TGT_N = 15,
  parameter logic [TGT_N-1:0] CONN_MASK = 15'h7BFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [RA_W-1:0]  tgt_addr,
  input  logic [PKT_W-1:0] img,
  output logic [TGT_N-1:0] pkt_valid,
  output logic [RA_W-1:0]  pkt_addr,
  output logic [PKT_W-1:0] pkt_data
);
  for (genvar g = 0; g < TGT_N; g++) begin : g_tgt
    if (CONN_MASK[g]) begin : g_on
      logic v_q;
      always_ff @(posedge clk) begin
        if (rst) v_q <= 1'b0;
        else     v_q <= fire;
      end
      assign pkt_valid[g] = v_q;
    end else begin : g_off
      assign pkt_valid[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_addr <= '0;
      pkt_data <= '0;
    end else if (fire) begin
      pkt_addr <= tgt_addr;
      pkt_data <= img;
    end
  end
endmodule

// File: rtl/cbw_rdresp.sv
module cbw_rdresp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  always_ff @(posedge clk) begin
    if (rst) rd_err <= 1'b0;
    else     rd_err <= rd_en;
    rd_data <= '0;
  end
endmodule

// File: rtl/cfg_bcast_writer.sv
module cfg_bcast_writer #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int RA_W   = 6,
  parameter int WIN_AW = 12,
  parameter int TGT_N  = 15,
  parameter logic [TGT_N-1:0] CONN_MASK  = 15'h7BFF,
  parameter logic [RA_W-1:0]  FDATA_ADDR = 6'h0C
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    wr_win,
  input  logic [WIN_AW-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [DATA_W/8-1:0]     wr_strb,
  input  logic                    rd_en,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_err,
  output logic [TGT_N-1:0]        pkt_valid,
  output logic [RA_W-1:0]         pkt_addr,
  output logic [WORDS*DATA_W-1:0] pkt_data
);
  localparam int PKT_W = WORDS * DATA_W;

  logic [WORDS-1:0] word_sel;
  logic             fire;
  logic [RA_W-1:0]  tgt_addr;
  logic [PKT_W-1:0] img;

  cbw_decode #(.DATA_W(DATA_W), .WORDS(WORDS), .RA_W(RA_W), .WIN_AW(WIN_AW),
               .FDATA_ADDR(FDATA_ADDR)) u_dec (
    .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr), .wr_strb(wr_strb),
    .word_sel(word_sel), .fire(fire), .tgt_addr(tgt_addr));

  cbw_wbuf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
    .clk(clk), .rst(rst), .word_sel(word_sel), .wr_data(wr_data),
    .next_img(img));

  cbw_fanout #(.PKT_W(PKT_W), .RA_W(RA_W), .TGT_N(TGT_N),
               .CONN_MASK(CONN_MASK)) u_fan (
    .clk(clk), .rst(rst), .fire(fire), .tgt_addr(tgt_addr), .img(img),
    .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_data(pkt_data));

  cbw_rdresp #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err));
endmodule

// File: rtl/cbw_chk.sv
module cbw_chk #(
  parameter int DATA_W = 32,
  parameter int RA_W   = 6,
  parameter int WIN_AW = 12,
  parameter int TGT_N  = 15,
  parameter logic [TGT_N-1:0] CONN_MASK  = 15'h7BFF,
  parameter logic [RA_W-1:0]  FDATA_ADDR = 6'h0C
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   wr_win,
  input logic [WIN_AW-1:0]      wr_addr,
  input logic [DATA_W/8-1:0]    wr_strb,
  input logic                   rd_en,
  input logic [DATA_W-1:0]      rd_data,
  input logic                   rd_err,
  input logic [TGT_N-1:0]       pkt_valid,
  input logic [RA_W-1:0]        pkt_addr
);
  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|pkt_valid) |-> $past(wr_en && (&wr_strb) && (wr_addr[3:2] == 2'd3)));
  // R3
  reg_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ((|pkt_valid) && !$past(wr_win)) |-> (pkt_addr == $past(wr_addr[9:4])));
  // R4
  fdata_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ((|pkt_valid) && $past(wr_win)) |-> (pkt_addr == FDATA_ADDR));
  // R5
  mask_chk: assert property (@(posedge clk) disable iff (rst)
    (|pkt_valid) |-> (pkt_valid == CONN_MASK));
  // R6
  partial_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(&wr_strb)) |=> (pkt_valid == '0));
  // R8
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_data == '0 && $past(rd_en)));
endmodule

bind cfg_bcast_writer cbw_chk #(
  .DATA_W(DATA_W), .RA_W(RA_W), .WIN_AW(WIN_AW), .TGT_N(TGT_N),
  .CONN_MASK(CONN_MASK), .FDATA_ADDR(FDATA_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr),
  .wr_strb(wr_strb), .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err),
  .pkt_valid(pkt_valid), .pkt_addr(pkt_addr)
);

// File: tb/tb_cfg_bcast_writer.sv
module tb_cfg_bcast_writer;
  localparam int CLK_PERIOD = 10;
  localparam logic [14:0] MASK  = 15'h7BFF;
  localparam logic [5:0]  FADDR = 6'h0C;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, wr_win = 1'b0, rd_en = 1'b0;
  logic [11:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [3:0]   wr_strb = '0;
  logic [31:0]  rd_data;
  logic         rd_err;
  logic [14:0]  pkt_valid;
  logic [5:0]   pkt_addr;
  logic [127:0] pkt_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [31:0]  model [4];
  logic [133:0] expq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_bcast_writer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .rd_en(rd_en), .rd_data(rd_data),
    .rd_err(rd_err), .pkt_valid(pkt_valid), .pkt_addr(pkt_addr),
    .pkt_data(pkt_data));

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // called at a falling edge; presents one write for one cycle
  task automatic wr(input logic win, input logic [11:0] addr,
                    input logic [31:0] data, input logic [3:0] strb);
    wr_en = 1'b1; wr_win = win; wr_addr = addr; wr_data = data; wr_strb = strb;
    if (strb == 4'hF) begin
      model[addr[3:2]] = data;
      if (addr[3:2] == 2'd3)
        expq.push_back({(win ? FADDR : addr[9:4]),
                        model[3], model[2], model[1], model[0]});
    end
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0;
  endtask

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    if (!rst && (|pkt_valid)) begin
      if (expq.size() == 0) begin
        check(1'b0, "R6 unexpected strobe", 128'(pkt_valid), 128'h0);
      end else begin
        logic [133:0] e;
        e = expq.pop_front();
        check(pkt_valid == MASK, "R5 strobe mask", 128'(pkt_valid), 128'(MASK));
        check(pkt_addr == e[133:128], "R3/R4 target addr", 128'(pkt_addr),
              128'(e[133:128]));
        check(pkt_data == e[127:0], "R2/R7 packet data", pkt_data, e[127:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 128'h0, 128'h1);
      report();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pkt_valid == '0, "R1 strobes low", 128'(pkt_valid), 128'h0);
    check(rd_err == 1'b0, "R1 rd_err low", 128'(rd_err), 128'h0);
    // R1 only word 3 after reset: lower words zero; R3 addr 0x1A
    wr(1'b0, 12'h1AC, 32'hCAFE0003, 4'hF);
    @(negedge clk);
    // R2 R3 full packet in register window, target 0x3F, scrambled order
    wr(1'b0, 12'h3F4, 32'h11111111, 4'hF);
    wr(1'b0, 12'h3F0, 32'h00000000, 4'hF);
    wr(1'b0, 12'h3F8, 32'h22222222, 4'hF);
    wr(1'b0, 12'hFF0, 32'hA5A5A5A5, 4'hF);
    wr(1'b0, 12'h3FC, 32'h33333333, 4'hF);
    @(negedge clk);
    // R4 frame-data window, address bits ignored
    wr(1'b1, 12'h520, 32'hDEAD0000, 4'hF);
    wr(1'b1, 12'h7E4, 32'hDEAD0001, 4'hF);
    wr(1'b1, 12'h008, 32'hDEAD0002, 4'hF);
    wr(1'b1, 12'hABC, 32'hDEAD0003, 4'hF);
    @(negedge clk);
    // R6 partial writes ignored (also to word 3: no strobe)
    wr(1'b0, 12'h004, 32'hBAD0BAD0, 4'h3);
    wr(1'b0, 12'h00C, 32'hBAD1BAD1, 4'h1);
    wr(1'b1, 12'h00C, 32'hBAD2BAD2, 4'hE);
    @(negedge clk);
    check(pkt_valid == '0, "R6 no strobe after partial", 128'(pkt_valid), 128'h0);
    // R7 retention and shared buffer: word 3 only, then back-to-back (R2)
    wr(1'b0, 12'h10C, 32'h77777777, 4'hF);
    wr(1'b1, 12'h00C, 32'h88888888, 4'hF);
    wr(1'b0, 12'h2AC, 32'h99999999, 4'hF);
    @(negedge clk);
    // R8 read response one cycle later
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_err == 1'b1, "R8 rd_err high", 128'(rd_err), 128'h1);
    check(rd_data == '0, "R8 rd_data zero", 128'(rd_data), 128'h0);
    @(negedge clk);
    check(rd_err == 1'b0, "R8 rd_err one cycle", 128'(rd_err), 128'h0);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R2 all packets seen", 128'(expq.size()), 128'h0);
    done = 1'b1;
    report();
  end
endmodule